// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block holds the transmit and receive queues of one UART channel, along with the control register that configures them. The host writes characters into the transmit queue and reads them from the receive queue. The serial side takes transmit characters with a pop strobe and delivers received characters with a push strobe. A single control write does four things: it turns queueing on or off, it can empty either queue independently through command bits that never stay set, it picks the receive threshold, and it picks the transmit threshold. Each threshold is 1, 4, 8 or 14 characters.

While queueing is off, each direction holds exactly one character and both thresholds act as 1. The receive interrupt follows the fill level against its threshold. The transmit interrupt comes from a three-state machine that remembers whether the last refill went above the threshold.

The machine has three states:
- `TX_FIRED`: the interrupt is asserted. This is the reset state and the state after a transmit flush.
- `TX_LOW`: the last refill did not go above the threshold, so the machine waits for empty.
- `TX_ABOVE`: the last refill went above the threshold, so the machine waits for the level to drop below it.

It has five transitions:
- FIRED→LOW: on a host write that leaves the level at or below the threshold.
- FIRED→ABOVE: on a host write that leaves the level above the threshold.
- LOW→ABOVE: on a host write that takes the level above the threshold.
- LOW→FIRED: when the level reaches zero.
- ABOVE→FIRED: when the level drops below the threshold.

A flush sends any state to FIRED.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `ctl_q` reads 0x00, both levels are 0, `rx_irq` is 0 and `tx_irq` is 1.
- R2: A control write with bit 0 set stores bits [7:6] (receive threshold), [5:4] (transmit threshold) and [3] (legacy mode flag) and sets the enable. `ctl_q` reads {rx_sel, tx_sel, flag, 2'b00, enable}. The flag has no effect on behaviour.
- R3: A control write with bit 0 clear clears only the enable. `ctl_q[7:3]` keeps its value.
- R4: A control write with bits 0 and 2 set empties the transmit queue: `tx_level` is 0 in the cycle after. The receive queue is untouched, and bit 2 reads back as 0.
- R5: A control write with bits 0 and 1 set empties the receive queue the same way. The transmit queue is untouched, and bit 1 reads back as 0.
- R6: Bits 2 and 1 do nothing in a write whose bit 0 is clear.
- R7: When enabled, a queue accepts up to DEPTH (16) characters. When disabled, it accepts a push only at level 0.
- R8: A push into a full queue is dropped, the stored contents are kept, and the overflow output is high for exactly the following cycle.
- R9: Characters leave in arrival order. Popped data appears on the read output the cycle after the pop and holds until the next successful pop. A pop from an empty queue changes nothing.
- R10: `rx_irq` is high exactly while `rx_level` ≥ the receive threshold. The encoding is 00→1, 01→4, 10→8, 11→14, and the threshold is 1 while disabled.
- R11: After a refill that takes `tx_level` above the transmit threshold (same encoding as R10), `tx_irq` rises in the cycle the level falls below that threshold.
- R12: If the last refill did not go above the threshold, `tx_irq` stays low until `tx_level` reaches 0.
- R13: An accepted host write drops `tx_irq`. A transmit flush raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| ctl_q | output | 8 | Stored control fields |
| host_wr | input | 1 | Host push into transmit queue |
| host_wdata | input | DATA_W | Host transmit character |
| host_rd | input | 1 | Host pop from receive queue |
| host_rdata | output | DATA_W | Last character popped by host |
| tx_pop | input | 1 | Serial side pop from transmit queue |
| tx_data | output | DATA_W | Last character popped by serial side |
| rx_push | input | 1 | Serial side push into receive queue |
| rx_data | input | DATA_W | Received character |
| tx_level | output | $clog2(DEPTH+1) | Transmit fill level |
| rx_level | output | $clog2(DEPTH+1) | Receive fill level |
| tx_ovf | output | 1 | Transmit push dropped (one cycle) |
| rx_ovf | output | 1 | Receive push dropped (one cycle) |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |

## Verification
Levels, read data, overflow flags and the transmit interrupt state all change at the clock edge that samples the stimulus, so each is due one cycle after it. The receive interrupt and `ctl_q` are derived from registers without further delay, so they are due in that same cycle. The bench drives every input just after an edge and updates its reference model with those inputs. It then compares all outputs 2 ns after the next edge, which keeps every check exactly one edge behind its stimulus.

// File: rtl/ufc_pkg.sv
`timescale 1ns/1ps
package ufc_pkg;

    typedef enum logic [1:0] {
        TX_FIRED = 2'd0,
        TX_LOW   = 2'd1,
        TX_ABOVE = 2'd2
    } txirq_e;

    function automatic int unsigned trig_chars(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ufc_fifo.sv
`timescale 1ns/1ps
module ufc_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic [$clog2(DEPTH+1)-1:0]   level_nxt,
    output logic                         push_ok,
    output logic                         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     cap;
    logic              pop_ok;

    assign cap     = en ? CW'(DEPTH) : CW'(1);
    assign push_ok = push && !flush && (level < cap);
    assign pop_ok  = pop && !flush && (level != '0);

    always_comb begin
        if (flush) begin
            level_nxt = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level_nxt = level + CW'(1);
                2'b01:   level_nxt = level - CW'(1);
                default: level_nxt = level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            rdata <= '0;
            ovf   <= 1'b0;
        end else begin
            level <= level_nxt;
            ovf   <= push && !flush && !(level < cap);
            if (flush) begin
                wp <= '0;
                rp <= '0;
            end else begin
                if (push_ok) wp <= wp + AW'(1);
                if (pop_ok) begin
                    rp    <= rp + AW'(1);
                    rdata <= mem[rp];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    p_level_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && level == cap) |=> ($stable(level) && ovf));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && level == '0) |=> ($stable(rdata) && level == '0));

endmodule

// File: rtl/ufc_txirq.sv
`timescale 1ns/1ps
module ufc_txirq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic [CW-1:0] lvl_nxt,
    input  logic [CW-1:0] trig,
    output logic          irq
);
    import ufc_pkg::*;

    txirq_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = TX_FIRED;
        end else begin
            unique case (state)
                TX_FIRED: if (push_ok)
                              state_nxt = (lvl_nxt > trig) ? TX_ABOVE : TX_LOW;
                TX_LOW:   if (lvl_nxt == '0)
                              state_nxt = TX_FIRED;
                          else if (push_ok && lvl_nxt > trig)
                              state_nxt = TX_ABOVE;
                TX_ABOVE: if (lvl_nxt < trig)
                              state_nxt = TX_FIRED;
                default:  state_nxt = TX_FIRED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_FIRED;
        else        state <= state_nxt;
    end

    always_comb begin
        irq = (state == TX_FIRED);
    end

    p_empty_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_LOW && !flush && lvl_nxt == '0) |=> irq);

    p_cross_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ABOVE && !flush && lvl_nxt < trig) |=> irq);

    p_write_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_FIRED && !flush && push_ok) |=> !irq);

endmodule

// File: rtl/uart_fifo_ctl.sv
`timescale 1ns/1ps
module uart_fifo_ctl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_wdata,
    output logic [7:0]                 ctl_q,
    input  logic                       host_wr,
    input  logic [DATA_W-1:0]          host_wdata,
    input  logic                       host_rd,
    output logic [DATA_W-1:0]          host_rdata,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_data,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_ovf,
    output logic                       rx_ovf,
    output logic                       rx_irq,
    output logic                       tx_irq
);
    import ufc_pkg::*;
    localparam int CW = $clog2(DEPTH+1);

    logic          fifo_en, mode_flag;
    logic [1:0]    rx_sel, tx_sel;
    logic          tx_flush, rx_flush;
    logic [CW-1:0] rx_trig, tx_trig, tx_lvl_nxt, rx_lvl_nxt;
    logic          tx_push_ok, rx_push_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            mode_flag <= 1'b0;
            rx_sel    <= 2'b00;
            tx_sel    <= 2'b00;
        end else if (cfg_we) begin
            fifo_en <= cfg_wdata[0];
            if (cfg_wdata[0]) begin
                rx_sel    <= cfg_wdata[7:6];
                tx_sel    <= cfg_wdata[5:4];
                mode_flag <= cfg_wdata[3];
            end
        end
    end

    assign tx_flush = cfg_we && cfg_wdata[0] && cfg_wdata[2];
    assign rx_flush = cfg_we && cfg_wdata[0] && cfg_wdata[1];
    assign ctl_q    = {rx_sel, tx_sel, mode_flag, 2'b00, fifo_en};
    assign rx_trig  = fifo_en ? CW'(trig_chars(rx_sel)) : CW'(1);
    assign tx_trig  = fifo_en ? CW'(trig_chars(tx_sel)) : CW'(1);

    ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .en(fifo_en), .flush(tx_flush),
        .push(host_wr), .wdata(host_wdata), .pop(tx_pop), .rdata(tx_data),
        .level(tx_level), .level_nxt(tx_lvl_nxt), .push_ok(tx_push_ok), .ovf(tx_ovf)
    );

    ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .en(fifo_en), .flush(rx_flush),
        .push(rx_push), .wdata(rx_data), .pop(host_rd), .rdata(host_rdata),
        .level(rx_level), .level_nxt(rx_lvl_nxt), .push_ok(rx_push_ok), .ovf(rx_ovf)
    );

    ufc_txirq #(.CW(CW)) u_txirq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push_ok(tx_push_ok),
        .lvl_nxt(tx_lvl_nxt), .trig(tx_trig), .irq(tx_irq)
    );

    assign rx_irq = (rx_level >= rx_trig);

    p_txflush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_level == '0 && tx_irq));

    p_rxflush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_level == '0));

    p_disable_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[0]) |=> (ctl_q[7:3] == $past(ctl_q[7:3]) && !ctl_q[0]));

    p_rx_irq_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_level != '0));

    p_disabled_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !cfg_we && rx_level <= CW'(1)) |=> (rx_level <= CW'(1)));

endmodule

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] ctl_q;
    logic host_wr = 1'b0, host_rd = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [DW-1:0] host_wdata = '0, rx_data = '0;
    logic [DW-1:0] host_rdata, tx_data;
    logic [CW-1:0] tx_level, rx_level;
    logic tx_ovf, rx_ovf, rx_irq, tx_irq;

    always #4 clk = ~clk;

    uart_fifo_ctl #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctl_q(ctl_q),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic       m_en = 0, m_dma = 0;
    logic [1:0] m_rxs = 0, m_txs = 0;
    logic [7:0] mq_tx[$];
    logic [7:0] mq_rx[$];
    logic [7:0] m_txd = 0, m_rxd = 0;
    bit         m_txo = 0, m_rxo = 0;
    int         m_st = 0;

    function automatic int tc(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        cfg_we = 0; host_wr = 0; host_rd = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic cycle();
        int cap, ttx, trx, nl;
        bit flt, flr, pk, wk;
        cap = m_en ? DEPTH : 1;
        ttx = m_en ? tc(m_txs) : 1;
        flt = cfg_we && cfg_wdata[0] && cfg_wdata[2];
        flr = cfg_we && cfg_wdata[0] && cfg_wdata[1];
        // transmit queue and interrupt state
        if (flt) begin
            mq_tx.delete(); m_txo = 0; m_st = 0;
        end else begin
            pk = tx_pop && mq_tx.size() > 0;
            wk = host_wr && mq_tx.size() < cap;
            m_txo = host_wr && !wk;
            if (pk) m_txd = mq_tx.pop_front();
            if (wk) mq_tx.push_back(host_wdata);
            nl = mq_tx.size();
            case (m_st)
                0: if (wk) m_st = (nl > ttx) ? 2 : 1;
                1: if (nl == 0) m_st = 0; else if (wk && nl > ttx) m_st = 2;
                default: if (nl < ttx) m_st = 0;
            endcase
        end
        // receive queue
        if (flr) begin
            mq_rx.delete(); m_rxo = 0;
        end else begin
            pk = host_rd && mq_rx.size() > 0;
            wk = rx_push && mq_rx.size() < cap;
            m_rxo = rx_push && !wk;
            if (pk) m_rxd = mq_rx.pop_front();
            if (wk) mq_rx.push_back(rx_data);
        end
        if (cfg_we) begin
            m_en = cfg_wdata[0];
            if (cfg_wdata[0]) begin
                m_rxs = cfg_wdata[7:6]; m_txs = cfg_wdata[5:4]; m_dma = cfg_wdata[3];
            end
        end
        @(posedge clk); #2;
        trx = m_en ? tc(m_rxs) : 1;
        check("R2 ctl_q", ctl_q, {m_rxs, m_txs, m_dma, 2'b00, m_en});
        check("R7 tx_level", tx_level, mq_tx.size());
        check("R7 rx_level", rx_level, mq_rx.size());
        check("R9 tx_data", tx_data, m_txd);
        check("R9 host_rdata", host_rdata, m_rxd);
        check("R8 tx_ovf", tx_ovf, m_txo);
        check("R8 rx_ovf", rx_ovf, m_rxo);
        check("R10 rx_irq", rx_irq, mq_rx.size() >= trx);
        check("R11 tx_irq", tx_irq, m_st == 0);
        idle_inputs();
    endtask

    task automatic ctl(input logic [7:0] v);
        cfg_we = 1; cfg_wdata = v; cycle();
    endtask
    task automatic hw(input logic [7:0] v);
        host_wr = 1; host_wdata = v; cycle();
    endtask
    task automatic tp();
        tx_pop = 1; cycle();
    endtask
    task automatic rp(input logic [7:0] v);
        rx_push = 1; rx_data = v; cycle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        check("R1 ctl_q", ctl_q, 0);
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 tx_irq", tx_irq, 1);
        @(posedge clk); #2;

        // R7 disabled mode holds one char, R8 drop
        rp(8'h11); rp(8'h22);
        check("R7 disabled rx_level", rx_level, 1);
        // R6 reset bits ignored without bit 0
        ctl(8'h06);
        check("R6 rx_level kept", rx_level, 1);
        host_rd = 1; cycle();
        check("R9 first char", host_rdata, 8'h11);

        // R3 disable keeps fields
        ctl(8'hF9);
        ctl(8'h00);
        check("R3 ctl_q", ctl_q, 8'hF8);

        // R4 / R5 flushes
        ctl(8'h01);
        hw(8'hA1); hw(8'hA2); hw(8'hA3);
        rp(8'h31); rp(8'h32);
        ctl(8'h05);
        check("R4 tx flushed", tx_level, 0);
        check("R4 rx kept", rx_level, 2);
        check("R4 self clear", ctl_q[2], 0);
        check("R13 flush raises irq", tx_irq, 1);
        ctl(8'h03);
        check("R5 rx flushed", rx_level, 0);
        check("R5 self clear", ctl_q[1], 0);

        // R12 shallow refill waits for empty (tx threshold 4)
        ctl(8'h11);
        hw(8'h01);
        check("R13 write clears irq", tx_irq, 0);
        hw(8'h02); hw(8'h03);
        tp();
        check("R12 no irq at 2", tx_irq, 0);
        tp();
        check("R12 no irq at 1", tx_irq, 0);
        tp();
        check("R12 irq at empty", tx_irq, 1);

        // R11 deep refill fires below threshold
        for (int i = 0; i < 6; i++) hw(8'(8'h40 + i));
        tp(); tp();
        check("R11 level 4 no irq", tx_irq, 0);
        tp();
        check("R11 irq below 4", tx_irq, 1);
        check("R9 order", tx_data, 8'h42);

        // R8 overflow at full
        ctl(8'h07);
        for (int i = 0; i < DEPTH; i++) rp(8'(i));
        rp(8'hEE);
        check("R8 rx_ovf pulse", rx_ovf, 1);
        check("R8 level full", rx_level, DEPTH);
        cycle();
        check("R8 pulse one cycle", rx_ovf, 0);

        // constrained random
        for (int c = 0; c < 4000; c++) begin
            bit fill;
            fill = ((c / 50) % 2) == 0;
            cfg_we    = ($urandom % 40) == 0;
            cfg_wdata = ($urandom % 8 == 0) ? 8'($urandom) & 8'hFE : 8'($urandom) | 8'h01;
            host_wr   = ($urandom % 4) < (fill ? 3 : 1);
            host_wdata = 8'($urandom);
            tx_pop    = ($urandom % 4) < (fill ? 1 : 3);
            rx_push   = ($urandom % 4) < (fill ? 3 : 1);
            rx_data   = 8'($urandom);
            host_rd   = ($urandom % 4) < (fill ? 1 : 3);
            cycle();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule